// File: doc/BRIEF.md
# Bus Control Strobe Generator with CALL-Aware Acknowledge Extension

This block sits between an 8-bit processor's multiplexed status/data bus and the rest of the system. At the start of every machine cycle the processor places a status byte on the bus and pulses a cycle-start signal. The block captures that byte, works out what kind of cycle follows, and then drives one of five active-low strobes: memory read, memory write, I/O read, I/O write or interrupt acknowledge. Read strobes are gated by the processor's read-enable. Write strobes are gated by its write pulse. Every strobe is registered, so it follows its gate by one clock.

During an interrupt acknowledge, the interrupt controller places an instruction on the data bus. If that instruction is the three-byte subroutine call, the processor then runs two more reads to fetch the call's target address. The controller, not memory, must supply those two bytes. The block watches the byte presented during the acknowledge. If it is the call opcode, the block turns up to two of the following read cycles into further acknowledge strobes and keeps the memory-read strobe inactive. A single-byte restart instruction is followed by a stack write and gets no extra strobes. Any cycle that does not match ends the extension early.

Top module: `bus_strobe_gen`

## Requirements
- R1: While reset is high, and on the clock after reset is released, all five strobes are high. A pending acknowledge extension is discarded, so the first read after reset with status 0x02 gives a memory-read strobe.
- R2: The status byte is taken from `d` only on a clock edge where `sync` is high. Values on `d` at other times do not change the cycle type.
- R3: In a cycle whose status has bit 1 = 1 (read), bit 4 = 0 (memory) and bit 0 = 0, `memr_n` is low on each clock that follows a clock where `dbin` was high.
- R4: In a cycle whose status has bit 1 = 0 (write), bit 4 = 0 and bit 0 = 0, `memw_n` is low on each clock that follows a clock where `wr_n` was low.
- R5: With status bit 4 = 1 and bit 0 = 0, a read cycle drives `ior_n` (gated by `dbin`) and a write cycle drives `iow_n` (gated by `wr_n`).
- R6: A cycle whose status has bit 0 = 1 is an acknowledge cycle. Unless R7 claims it, it drives `inta_n` (gated by `dbin`) and never `memr_n`.
- R7: If the byte on `d` while `dbin` is high in an acknowledge cycle is 0xCD (call), then each of the next two cycles whose status is 0x02 or 0x03 drives `inta_n` instead of `memr_n`. That gives three acknowledge strobes in total. A third such read is handled normally.
- R8: If the acknowledged byte is not 0xCD (for example a restart), no extension occurs. A following stack write gives `memw_n`, and a following 0x02 read gives `memr_n`.
- R9: Any cycle that is neither an acknowledge nor an eligible extension read cancels the remaining extension count.
- R10: At most one strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Cycle start; status byte valid on `d` |
| dbin | input | 1 | Processor read enable |
| wr_n | input | 1 | Processor write pulse, active low |
| d | input | DATA_W | Multiplexed status/data bus |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |

## Verification
A wrong cycle type or extension count always shows up on the next strobe gated by `dbin` or `wr_n`. It appears one clock after the gate rises, as the wrong line going low. The most telling case is a stale or lost count. It turns one of the follow-on reads after a call from an acknowledge into a memory read, or the reverse. This is visible within the first or second read cycle after the acknowledge. A sweep of all 256 status values after a neutral write confirms the basic decode. Directed sequences cover call, restart, interruption and reset in mid-extension.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic [2:0] {
    K_IDLE = 3'd0,
    K_MRD  = 3'd1,
    K_MWR  = 3'd2,
    K_IORD = 3'd3,
    K_IOWR = 3'd4,
    K_ACK  = 3'd5,
    K_XACK = 3'd6
  } cyc_kind_e;

  function automatic logic kind_is_ack(cyc_kind_e k);
    return (k == K_ACK) || (k == K_XACK);
  endfunction

endpackage

// File: rtl/bsg_status_decode.sv
module bsg_status_decode #(
  parameter int          DATA_W  = 8,
  parameter int          ACK_BIT = 0,
  parameter int          RD_BIT  = 1,
  parameter int          IO_BIT  = 4,
  parameter logic [7:0]  CALL_OP = 8'hCD
) (
  input  logic [DATA_W-1:0] d,
  output logic              f_ack,
  output logic              f_rd,
  output logic              f_io,
  output logic              f_call
);

  localparam logic [DATA_W-1:0] CALL_W = DATA_W'(CALL_OP);

  // field extraction from the status byte
  always_comb begin
    f_ack  = d[ACK_BIT];
    f_rd   = d[RD_BIT];
    f_io   = d[IO_BIT];
    f_call = (d == CALL_W);
  end

  initial begin
    if (ACK_BIT >= DATA_W || RD_BIT >= DATA_W || IO_BIT >= DATA_W)
      $error("status bit index out of range");
  end

endmodule

// File: rtl/bsg_cycle_tracker.sv
module bsg_cycle_tracker
  import bsg_pkg::*;
#(
  parameter int NREMAP      = 2,
  parameter bit OPCODE_QUAL = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sync,
  input  logic      dbin,
  input  logic      f_ack,
  input  logic      f_rd,
  input  logic      f_io,
  input  logic      f_call,
  output cyc_kind_e kind_q
);

  localparam int CNT_W = $clog2(NREMAP + 1);

  logic [CNT_W-1:0] rem_q;
  logic             call_q;
  logic             armed;
  logic             elig;
  cyc_kind_e        kind_d;
  logic [CNT_W-1:0] rem_d;

  // opcode qualification variant
  generate
    if (OPCODE_QUAL) begin : g_qual
      assign armed = call_q;
    end else begin : g_noqual
      assign armed = 1'b1;
    end
  endgenerate

  // a follow-on address read is eligible for remap
  always_comb begin
    elig = f_rd && !f_io &&
           (((kind_q == K_ACK) && armed) ||
            ((kind_q == K_XACK) && (rem_q != '0)));
  end

  always_comb begin
    kind_d = kind_q;
    rem_d  = rem_q;
    if (sync) begin
      rem_d = '0;
      if (elig) begin
        kind_d = K_XACK;
        rem_d  = (kind_q == K_ACK) ? CNT_W'(NREMAP - 1) : rem_q - 1'b1;
      end else if (f_ack) begin
        kind_d = K_ACK;
      end else if (f_rd) begin
        kind_d = f_io ? K_IORD : K_MRD;
      end else begin
        kind_d = f_io ? K_IOWR : K_MWR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= K_IDLE;
      rem_q  <= '0;
      call_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      rem_q  <= rem_d;
      if (sync)
        call_q <= 1'b0;
      else if ((kind_q == K_ACK) && dbin && f_call)
        call_q <= 1'b1;
    end
  end

  // R7
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_q == K_XACK) |-> (rem_q < CNT_W'(NREMAP)));

  // R9
  break_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (sync && !kind_is_ack(kind_q)) |=> (kind_q != K_XACK));

  // R2
  hold_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync && kind_q != K_IDLE) |=> (kind_q != K_IDLE));

  generate
    if (OPCODE_QUAL) begin : g_qual_chk
      // R8
      no_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (sync && kind_q == K_ACK && !call_q) |=> (kind_q != K_XACK));
    end
  endgenerate

endmodule

// File: rtl/bsg_strobe_drive.sv
module bsg_strobe_drive
  import bsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      dbin,
  input  logic      wr_n,
  input  cyc_kind_e kind,
  output logic      memr_n,
  output logic      memw_n,
  output logic      ior_n,
  output logic      iow_n,
  output logic      inta_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      memr_n <= 1'b1;
      memw_n <= 1'b1;
      ior_n  <= 1'b1;
      iow_n  <= 1'b1;
      inta_n <= 1'b1;
    end else begin
      memr_n <= !((kind == K_MRD)  && dbin);
      ior_n  <= !((kind == K_IORD) && dbin);
      inta_n <= !(kind_is_ack(kind) && dbin);
      memw_n <= !((kind == K_MWR)  && !wr_n);
      iow_n  <= !((kind == K_IOWR) && !wr_n);
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (memr_n && memw_n && ior_n && iow_n && inta_n));

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~memr_n, ~memw_n, ~ior_n, ~iow_n, ~inta_n}) <= 1);

  // R6
  ack_no_memr_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_is_ack(kind) && dbin) |=> (!inta_n && memr_n));

  // R3
  memr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == K_MRD && dbin) |=> !memr_n);

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          ACK_BIT     = 0,
  parameter int          RD_BIT      = 1,
  parameter int          IO_BIT      = 4,
  parameter logic [7:0]  CALL_OP     = 8'hCD,
  parameter int          NREMAP      = 2,
  parameter bit          OPCODE_QUAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic              dbin,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] d,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic              inta_n
);

  logic      f_ack, f_rd, f_io, f_call;
  cyc_kind_e kind;

  bsg_status_decode #(
    .DATA_W (DATA_W),
    .ACK_BIT(ACK_BIT),
    .RD_BIT (RD_BIT),
    .IO_BIT (IO_BIT),
    .CALL_OP(CALL_OP)
  ) u_decode (
    .d     (d),
    .f_ack (f_ack),
    .f_rd  (f_rd),
    .f_io  (f_io),
    .f_call(f_call)
  );

  bsg_cycle_tracker #(
    .NREMAP     (NREMAP),
    .OPCODE_QUAL(OPCODE_QUAL)
  ) u_track (
    .clk   (clk),
    .rst   (rst),
    .sync  (sync),
    .dbin  (dbin),
    .f_ack (f_ack),
    .f_rd  (f_rd),
    .f_io  (f_io),
    .f_call(f_call),
    .kind_q(kind)
  );

  bsg_strobe_drive u_drive (
    .clk   (clk),
    .rst   (rst),
    .dbin  (dbin),
    .wr_n  (wr_n),
    .kind  (kind),
    .memr_n(memr_n),
    .memw_n(memw_n),
    .ior_n (ior_n),
    .iow_n (iow_n),
    .inta_n(inta_n)
  );

endmodule

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync = 1'b0;
  logic       dbin = 1'b0;
  logic       wr_n = 1'b1;
  logic [7:0] d = 8'h00;
  logic       memr_n, memw_n, ior_n, iow_n, inta_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  // bench model of the requirements
  int       m_kind = 0;   // 0 idle 1 mrd 2 mwr 3 iord 4 iowr 5 ack 6 ext-ack
  int       m_rem = 0;
  bit       m_call = 1'b0;

  always #2.5 clk = ~clk;

  bus_strobe_gen u_dut (
    .clk(clk), .rst(rst), .sync(sync), .dbin(dbin), .wr_n(wr_n), .d(d),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .inta_n(inta_n)
  );

  function automatic logic [4:0] strobes();
    return {memr_n, memw_n, ior_n, iow_n, inta_n};
  endfunction

  task automatic check(input logic [4:0] exp, input string req);
    n_chk++;
    if (strobes() !== exp) begin
      n_fail++;
      $display("FAIL %s: strobes {memr,memw,ior,iow,inta} actual %b expected %b",
               req, strobes(), exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sync = 1'b0; dbin = 1'b0; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    check(5'b11111, "R1");
    rst = 1'b0;
    @(negedge clk);
    check(5'b11111, "R1");
    m_kind = 0; m_rem = 0; m_call = 1'b0;
  endtask

  task automatic bus_cycle(input logic [7:0] st, input logic [7:0] dat, input string req);
    bit rd, io, ack, elig, rph;
    logic [4:0] exp;
    rd = st[1]; io = st[4]; ack = st[0];
    elig = rd && !io && ((m_kind == 5 && m_call) || (m_kind == 6 && m_rem > 0));
    if (elig) begin
      m_rem  = (m_kind == 5) ? 1 : m_rem - 1;
      m_kind = 6;
    end else begin
      m_rem = 0;
      if (ack)     m_kind = 5;
      else if (rd) m_kind = io ? 3 : 1;
      else         m_kind = io ? 4 : 2;
    end
    m_call = (m_kind == 5) && (dat == 8'hCD);
    rph = rd || ack;
    exp = 5'b11111;
    case (m_kind)
      1: if (rph)  exp[4] = 1'b0;
      2: if (!rph) exp[3] = 1'b0;
      3: if (rph)  exp[2] = 1'b0;
      4: if (!rph) exp[1] = 1'b0;
      5, 6: if (rph) exp[0] = 1'b0;
      default: ;
    endcase
    @(negedge clk); sync = 1'b1; d = st;
    @(negedge clk); sync = 1'b0; d = dat;
    if (rph) dbin = 1'b1; else wr_n = 1'b0;
    @(negedge clk); check(exp, req);
    @(negedge clk); check(exp, req);
    dbin = 1'b0; wr_n = 1'b1;
    @(negedge clk); check(5'b11111, "R10");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2 R3 R4 R5 R6: sweep all status bytes after a neutral write, bus data differs from status
    for (int s = 0; s < 256; s++) begin
      bus_cycle(8'h00, 8'h5A, "R4");
      bus_cycle(8'(s), ~8'(s), "R2/R3/R5/R6");
    end

    // R7: call acknowledged, two address reads remapped, third read normal
    bus_cycle(8'h23, 8'hCD, "R6");
    bus_cycle(8'h02, 8'h34, "R7");
    bus_cycle(8'h03, 8'h12, "R7");
    bus_cycle(8'h02, 8'h00, "R7");

    // R7: call then stack writes, no further remap
    bus_cycle(8'h23, 8'hCD, "R6");
    bus_cycle(8'h02, 8'h00, "R7");
    bus_cycle(8'h02, 8'h10, "R7");
    bus_cycle(8'h04, 8'h00, "R4");
    bus_cycle(8'h02, 8'h00, "R3");

    // R8: restart acknowledged, stack write then read stay normal
    bus_cycle(8'h23, 8'hFF, "R6");
    bus_cycle(8'h04, 8'h00, "R8");
    bus_cycle(8'h23, 8'hC7, "R6");
    bus_cycle(8'h02, 8'h00, "R8");

    // R9: interrupted extension is cancelled
    bus_cycle(8'h23, 8'hCD, "R6");
    bus_cycle(8'h02, 8'h00, "R7");
    bus_cycle(8'h04, 8'h00, "R9");
    bus_cycle(8'h02, 8'h00, "R9");

    // R9: I/O read after acknowledge is not an eligible read
    bus_cycle(8'h23, 8'hCD, "R6");
    bus_cycle(8'h12, 8'h00, "R9");
    bus_cycle(8'h02, 8'h00, "R9");

    // R7: acknowledge status repeated past the extension starts a new acknowledge
    bus_cycle(8'h23, 8'hCD, "R6");
    bus_cycle(8'h03, 8'h00, "R7");
    bus_cycle(8'h03, 8'h00, "R7");
    bus_cycle(8'h03, 8'hCD, "R6");
    bus_cycle(8'h02, 8'h00, "R7");

    // R1: reset in mid-extension discards it
    bus_cycle(8'h23, 8'hCD, "R6");
    bus_cycle(8'h02, 8'h00, "R7");
    do_reset();
    bus_cycle(8'h02, 8'h00, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule